// File: doc/BRIEF.md
# Single-Entry Write Buffer with Atomic Compare-and-Swap

This block sits between one processor's pipeline and a shared memory. It holds at most one pending write: an occupancy flag, a 16-bit target address and a 16-bit data word. A STORE from the pipeline parks the accumulator value and its address in the entry. The entry drains to shared memory only when an external grant arrives. Until then other processors may still see the old memory contents, so sequential consistency is relaxed by exactly one write.

The block also decides when the pipeline must wait. A FENCE waits while the entry is occupied. A CAS also waits while the entry is occupied. Once the entry is empty, the CAS reads the target word through a combinational read port and compares it with the expectation value. If the two match, it writes the new value in that same cycle, so no other access can come between the read and the write. The CAS returns a completion pulse and a success flag and does not alter the accumulator. The pipeline is assumed to raise at most one request per cycle. Forwarding buffered data to loads and arbitration between processors are handled elsewhere.

Top module: `wbuf_cas_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the entry becomes empty, with `buf_full`=0 and `buf_addr`=`buf_data`=0.
- R2: `st_req` with the entry empty gives `stall`=0. After the next edge, `buf_full`=1, `buf_addr` equals the request address and `buf_data` equals the request data.
- R3: While `buf_full`=1 and `flush_gnt`=1, the same cycle shows `mem_we`=1, `mem_waddr`=`buf_addr` and `mem_wdata`=`buf_data`. The entry is empty after that edge unless a store is accepted in the same cycle.
- R4: While `buf_full`=1 and `flush_gnt`=0, `mem_we`=0, and the entry keeps its flag, address and data across the edge.
- R5: `st_req` with the entry occupied and no grant gives `stall`=1, and the entry contents stay unchanged.
- R6: `st_req` with the entry occupied and the grant present drains the old entry and takes the new store in the same cycle. `stall` is 0, and after the edge the entry holds the new address and data with `buf_full`=1.
- R7: `fence_req` gives `stall`=1 exactly when `buf_full`=1, including a cycle in which the entry drains. With the entry empty it leaves the entry and the memory write port untouched.
- R8: `cas_req` while `buf_full`=1 gives `stall`=1 and `cas_done`=0, and the CAS performs no memory write.
- R9: `cas_req` with the entry empty, where `mem_rdata` equals `cas_expect`, gives in the same cycle `cas_done`=1, `cas_ok`=1, `mem_we`=1, `mem_waddr`=`cas_addr` and `mem_wdata`=`cas_new`. `mem_raddr` carries `cas_addr`.
- R10: `cas_req` with the entry empty, where `mem_rdata` differs from `cas_expect`, gives `cas_done`=1, `cas_ok`=0 and `mem_we`=0.
- R11: `flush_gnt` with the entry empty and no CAS has no effect: `mem_we`=0 and the entry stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_req | input | 1 | Store request |
| st_addr | input | 16 | Store target address |
| st_data | input | 16 | Store data (accumulator) |
| fence_req | input | 1 | Fence request |
| cas_req | input | 1 | Compare-and-swap request |
| cas_addr | input | 16 | CAS target address |
| cas_expect | input | 16 | CAS expectation value |
| cas_new | input | 16 | CAS value to write (accumulator) |
| flush_gnt | input | 1 | Permission to drain the entry this cycle |
| mem_rdata | input | 16 | Shared memory read data for CAS |
| stall | output | 1 | Pipeline must hold the current request |
| cas_done | output | 1 | CAS completed this cycle |
| cas_ok | output | 1 | CAS comparison matched and the write happened |
| buf_full | output | 1 | Entry occupied |
| buf_addr | output | 16 | Buffered address |
| buf_data | output | 16 | Buffered data |
| mem_we | output | 1 | Shared memory write enable |
| mem_waddr | output | 16 | Shared memory write address |
| mem_wdata | output | 16 | Shared memory write data |
| mem_raddr | output | 16 | Shared memory read address |

## Verification
A drain and a new store can fall in the same cycle. This happens when a store arrives while the entry is occupied and the grant is present. The bench sets this up on purpose, first in a directed case and then repeatedly in a random phase with a grant rate of about one half. The behavioural model expects the old address and data on the write port in that cycle, no stall, and the new address and data in the entry after the edge. The pairing of a fence or CAS with a draining grant is judged the same way: the request must still stall for that one cycle and proceed on the next.

// File: rtl/wbuf_pkg.sv
// Shared types for the write buffer.
// Assumes: the flush and the CAS never own the write port in the same cycle.
package wbuf_pkg;

    // Which producer owns the shared memory write port this cycle
    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_DRAIN = 2'd1,
        WR_SWAP  = 2'd2
    } wr_src_e;

    // Draining takes precedence; it can only occur while the entry is occupied
    function automatic wr_src_e pick_src(input logic drain, input logic swap);
        if (drain)
            return WR_DRAIN;
        else if (swap)
            return WR_SWAP;
        else
            return WR_IDLE;
    endfunction

endpackage

// File: rtl/wbuf_entry.sv
// Storage for the single buffered write: an occupancy flag, an address and data.
// Assumes: load and clear may both be high, and load then wins (drain plus refill).
module wbuf_entry #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              full,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    // Occupancy flag: set by an accepted store, cleared by a drain
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (load)
            full <= 1'b1;
        else if (clear)
            full <= 1'b0;
    end

    // Address and data capture on an accepted store only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            data <= '0;
        end else if (load) begin
            addr <= in_addr;
            data <= in_data;
        end
    end

endmodule

// File: rtl/wbuf_gate.sv
// Request gating: decides stall, store acceptance, draining and CAS start.
// Assumes: at most one of st_req, fence_req and cas_req is high per cycle.
module wbuf_gate (
    input  logic full,
    input  logic st_req,
    input  logic fence_req,
    input  logic cas_req,
    input  logic flush_gnt,
    output logic stall,
    output logic take_store,
    output logic drain,
    output logic cas_go
);

    logic st_blocked;
    logic barrier_blocked;

    // Drain whenever occupied and granted; a store may refill in the same cycle
    always_comb begin
        drain      = full && flush_gnt;
        take_store = st_req && (!full || flush_gnt);
        st_blocked = st_req && full && !flush_gnt;
    end

    // Barrier-class requests wait on the current occupancy, grant or not
    always_comb begin
        barrier_blocked = (fence_req || cas_req) && full;
        cas_go          = cas_req && !full;
        stall           = st_blocked || barrier_blocked;
    end

endmodule

// File: rtl/wbuf_atomic.sv
// Single-cycle compare for CAS. The compare is split into lanes of LANE_W bits
// that reduce in parallel. Assumes: mem_rdata is valid combinationally for the
// read address in the same cycle.
module wbuf_atomic #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 4
) (
    input  logic              cas_go,
    input  logic [DATA_W-1:0] expect_val,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              ok
);

    localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W;
    localparam int PAD_W = LANES * LANE_W;

    logic [PAD_W-1:0] exp_pad;
    logic [PAD_W-1:0] rd_pad;
    logic [LANES-1:0] lane_eq;

    // Zero-extend both operands so every lane has the same width
    always_comb begin
        exp_pad = PAD_W'(expect_val);
        rd_pad  = PAD_W'(mem_rdata);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane equality
        assign lane_eq[g] = (exp_pad[g*LANE_W +: LANE_W] == rd_pad[g*LANE_W +: LANE_W]);
    end

    // Completion and success are reported in the same cycle
    always_comb begin
        done = cas_go;
        ok   = cas_go && (&lane_eq);
    end

endmodule

// File: rtl/wbuf_cas_unit.sv
// Top level: a single-entry write buffer in front of shared memory, plus an
// atomic compare-and-swap. The write port is shared by the drain and the CAS.
// Assumes: the pipeline holds a stalled request steady and asserts at most one
// request per cycle.
module wbuf_cas_unit
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              fence_req,
    input  logic              cas_req,
    input  logic [ADDR_W-1:0] cas_addr,
    input  logic [DATA_W-1:0] cas_expect,
    input  logic [DATA_W-1:0] cas_new,
    input  logic              flush_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              stall,
    output logic              cas_done,
    output logic              cas_ok,
    output logic              buf_full,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr
);

    logic    take_store;
    logic    drain;
    logic    cas_go;
    wr_src_e wsrc;

    wbuf_gate u_gate (
        .full       (buf_full),
        .st_req     (st_req),
        .fence_req  (fence_req),
        .cas_req    (cas_req),
        .flush_gnt  (flush_gnt),
        .stall      (stall),
        .take_store (take_store),
        .drain      (drain),
        .cas_go     (cas_go)
    );

    wbuf_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entry (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_store),
        .clear   (drain),
        .in_addr (st_addr),
        .in_data (st_data),
        .full    (buf_full),
        .addr    (buf_addr),
        .data    (buf_data)
    );

    wbuf_atomic #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_atomic (
        .cas_go     (cas_go),
        .expect_val (cas_expect),
        .mem_rdata  (mem_rdata),
        .done       (cas_done),
        .ok         (cas_ok)
    );

    // The read port always points at the CAS target
    assign mem_raddr = cas_addr;

    // Write port multiplexer: drain or successful swap
    always_comb begin
        wsrc = pick_src(drain, cas_ok);
        unique case (wsrc)
            WR_DRAIN: begin
                mem_we    = 1'b1;
                mem_waddr = buf_addr;
                mem_wdata = buf_data;
            end
            WR_SWAP: begin
                mem_we    = 1'b1;
                mem_waddr = cas_addr;
                mem_wdata = cas_new;
            end
            default: begin
                mem_we    = 1'b0;
                mem_waddr = '0;
                mem_wdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/wbuf_cas_chk.sv
// Property checker for wbuf_cas_unit, attached with bind below.
module wbuf_cas_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_req,
    input logic [ADDR_W-1:0] st_addr,
    input logic [DATA_W-1:0] st_data,
    input logic              fence_req,
    input logic              cas_req,
    input logic [ADDR_W-1:0] cas_addr,
    input logic [DATA_W-1:0] cas_new,
    input logic              flush_gnt,
    input logic              stall,
    input logic              cas_done,
    input logic              cas_ok,
    input logic              buf_full,
    input logic [ADDR_W-1:0] buf_addr,
    input logic [DATA_W-1:0] buf_data,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] mem_raddr
);

    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> !buf_full && buf_addr == '0 && buf_data == '0);

    p_store_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !buf_full |=> buf_full && buf_addr == $past(st_addr) && buf_data == $past(st_data));

    p_drain_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && flush_gnt |-> mem_we && mem_waddr == buf_addr && mem_wdata == buf_data);

    p_drain_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && flush_gnt && !st_req |=> !buf_full);

    p_hold_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && !flush_gnt && !st_req |=> buf_full && buf_addr == $past(buf_addr) && buf_data == $past(buf_data));

    p_store_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && buf_full && !flush_gnt |-> stall);

    p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && buf_full && flush_gnt |-> !stall);

    p_fence_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req |-> stall == buf_full);

    p_cas_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cas_req && buf_full |-> stall && !cas_done);

    p_cas_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cas_done && cas_ok |-> mem_we && mem_waddr == cas_addr && mem_wdata == cas_new && mem_raddr == cas_addr);

    p_cas_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cas_done && !cas_ok |-> !mem_we);

    p_idle_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_full && !cas_req |-> !mem_we);

    p_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_req, fence_req, cas_req}));

endmodule

bind wbuf_cas_unit wbuf_cas_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_req     (st_req),
    .st_addr    (st_addr),
    .st_data    (st_data),
    .fence_req  (fence_req),
    .cas_req    (cas_req),
    .cas_addr   (cas_addr),
    .cas_new    (cas_new),
    .flush_gnt  (flush_gnt),
    .stall      (stall),
    .cas_done   (cas_done),
    .cas_ok     (cas_ok),
    .buf_full   (buf_full),
    .buf_addr   (buf_addr),
    .buf_data   (buf_data),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_raddr  (mem_raddr)
);

// File: tb/sim_wbuf_cas_unit.sv
module sim_wbuf_cas_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req = 1'b0, fence_req = 1'b0, cas_req = 1'b0, flush_gnt = 1'b0;
    logic [15:0] st_addr = '0, st_data = '0, cas_addr = '0, cas_expect = '0, cas_new = '0;
    logic [15:0] mem_rdata;
    logic        stall, cas_done, cas_ok, buf_full, mem_we;
    logic [15:0] buf_addr, buf_data, mem_waddr, mem_wdata, mem_raddr;

    logic [15:0] tmem [16];
    int          n_chk = 0, n_fail = 0;
    bit          m_full = 0;
    logic [15:0] m_addr = '0, m_data = '0;
    bit          finished = 0;

    always #2 clk = ~clk;

    assign mem_rdata = tmem[mem_raddr[3:0]];

    wbuf_cas_unit u0 (
        .clk(clk), .rst_n(rst_n), .st_req(st_req), .st_addr(st_addr), .st_data(st_data),
        .fence_req(fence_req), .cas_req(cas_req), .cas_addr(cas_addr), .cas_expect(cas_expect),
        .cas_new(cas_new), .flush_gnt(flush_gnt), .mem_rdata(mem_rdata), .stall(stall),
        .cas_done(cas_done), .cas_ok(cas_ok), .buf_full(buf_full), .buf_addr(buf_addr),
        .buf_data(buf_data), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_raddr(mem_raddr)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare against the model, then advance the model
    task automatic step(input string tag, input bit s, input bit f, input bit c, input bit g,
                        input logic [15:0] sa, input logic [15:0] sd,
                        input logic [15:0] ca, input logic [15:0] ce, input logic [15:0] cn);
        bit e_stall, e_we, e_done, e_ok, drain, go, take;
        logic [15:0] e_wa, e_wd;
        st_req = s; fence_req = f; cas_req = c; flush_gnt = g;
        st_addr = sa; st_data = sd; cas_addr = ca; cas_expect = ce; cas_new = cn;
        #1;
        drain   = m_full && g;
        go      = c && !m_full;
        take    = s && (!m_full || g);
        e_done  = go;
        e_ok    = go && (tmem[ca[3:0]] == ce);
        e_stall = (s && m_full && !g) || (f && m_full) || (c && m_full);
        e_we    = drain || e_ok;
        e_wa    = drain ? m_addr : (e_ok ? ca : 16'h0);
        e_wd    = drain ? m_data : (e_ok ? cn : 16'h0);
        chk(tag, "buf_full", {31'b0, buf_full}, {31'b0, m_full});
        chk(tag, "buf_addr", {16'b0, buf_addr}, {16'b0, m_addr});
        chk(tag, "buf_data", {16'b0, buf_data}, {16'b0, m_data});
        chk(tag, "stall", {31'b0, stall}, {31'b0, e_stall});
        chk(tag, "mem_we", {31'b0, mem_we}, {31'b0, e_we});
        if (e_we) begin
            chk(tag, "mem_waddr", {16'b0, mem_waddr}, {16'b0, e_wa});
            chk(tag, "mem_wdata", {16'b0, mem_wdata}, {16'b0, e_wd});
        end
        chk(tag, "cas_done", {31'b0, cas_done}, {31'b0, e_done});
        chk(tag, "cas_ok", {31'b0, cas_ok}, {31'b0, e_ok});
        if (c) chk(tag, "mem_raddr", {16'b0, mem_raddr}, {16'b0, ca});
        @(posedge clk);
        if (e_we) tmem[e_wa[3:0]] = e_wd;
        if (take) begin m_full = 1; m_addr = sa; m_data = sd; end
        else if (drain) m_full = 0;
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input bit g);
        step(tag, 0, 0, 0, g, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) tmem[i] = 16'(i * 16'h0101);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset leaves the entry empty
        idle("R1", 0);
        // R11: grant with nothing buffered does nothing
        idle("R11", 1);
        // R2: store into an empty entry
        step("R2", 1, 0, 0, 0, 16'h0003, 16'h1234, 0, 0, 0);
        // R4: occupied, no grant, entry held
        idle("R4", 0);
        // R5: second store blocked without a grant
        step("R5", 1, 0, 0, 0, 16'h0007, 16'h5555, 0, 0, 0);
        // R7: fence waits while occupied
        step("R7", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R8: CAS waits while occupied
        step("R8", 0, 0, 1, 0, 0, 0, 16'h0003, 16'h0303, 16'hAAAA);
        // R6: store with grant drains the old entry and refills
        step("R6", 1, 0, 0, 1, 16'h0005, 16'hBEEF, 0, 0, 0);
        // R7: fence still stalls in the draining cycle
        step("R7", 0, 1, 0, 1, 0, 0, 0, 0, 0);
        // R3: entry now empty, old drained value visible
        idle("R3", 0);
        // R7: fence on an empty entry passes
        step("R7", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R9: matching CAS writes the new value
        step("R9", 0, 0, 1, 0, 0, 0, 16'h0005, 16'hBEEF, 16'h0042);
        // R10: mismatching CAS leaves memory alone
        step("R10", 0, 0, 1, 0, 0, 0, 16'h0005, 16'hBEEF, 16'h0099);
        // R9: read back through another matching CAS
        step("R9", 0, 0, 1, 0, 0, 0, 16'h0005, 16'h0042, 16'h0043);
        // R3: plain drain after a fresh store
        step("R2", 1, 0, 0, 0, 16'h000A, 16'h7777, 0, 0, 0);
        idle("R3", 1);
        idle("R11", 1);
        // Mixed traffic, R6 overlaps of drain with refill happen often
        for (int i = 0; i < 2000; i++) begin
            int k = $urandom_range(0, 3);
            logic [15:0] a = 16'($urandom_range(0, 15));
            logic [15:0] d = 16'($urandom);
            logic [15:0] e = $urandom_range(0, 1) ? tmem[a[3:0]] : 16'($urandom);
            bit gg = $urandom_range(0, 1) == 1;
            step("R6", k == 1, k == 2, k == 3, gg, a, d, a, e, d ^ 16'h5A5A);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule